// File: doc/BRIEF.md
# Machine State Register Control Unit

This block owns the 64-bit machine state register of a processor core and applies every architectural update to it. The update rules differ for each operation: reset, interrupt entry, return from interrupt with a saved image, move-to with a full or partial update, and move-from. Each rule touches its own set of fields and keeps the others. When the value that results puts the core in problem state, three translation and enable bits are forced on.

The unit also decides, in the cycle an instruction is presented, whether that instruction may run. It raises a privilege-fault strobe when a privileged operation arrives in problem state. It raises a take-interrupt strobe for a pending asynchronous interrupt, but only while a valid instruction is presented and external interrupts are enabled. A stalled multi-cycle instruction therefore completes before the interrupt is taken. A load or store is not passed on in a cycle that takes an interrupt. Decode, the saved-register file and the branch to the vector belong to neighbouring blocks.

Top module: `msr_ctrl_unit`

## Requirements
- R1: Bit positions are SF=63, HV=60, EE=15, PR=14, ME=12, IR=5, DR=4, RI=1, LE=0. While reset is low the register holds 0x8000_0000_0000_0001, and `take_irq`, `priv_fault` and `ls_go` are 0.
- R2: On interrupt entry (`take_irq` or `priv_fault` high at a clock edge), SF and LE become 1 and PR, IR, DR and RI become 0. Every other bit keeps its value, and the presented instruction has no effect.
- R3: `take_irq` is 1 exactly when `op_valid`, `irq_pending` and EE are all 1. With `op_valid` low, a pending interrupt waits and the register is unchanged.
- R4: Operation codes are NOP=0, MTMSR=1, MFMSR=2, RFI=3, MTSPR=4, MFSPR=5, PRIV=6, LDST=7. With PR=1 and no interrupt taken, MTMSR, MFMSR, RFI and PRIV raise `priv_fault`. MTSPR and MFSPR raise it only when bit 20 of `insn_word` is 1. A faulting instruction does not execute.
- R5: MTMSR with `op_l`=1 copies only EE and RI from `operand`.
- R6: MTMSR with `op_l`=0 copies every bit from `operand` except HV, ME and LE, which keep their values.
- R7: After MTMSR or RFI, if PR is 1 in the result, EE, IR and DR are 1.
- R8: RFI copies `saved_val` into every bit except HV and the partial-function fields (bits 36:33 and 47:42), which keep their values.
- R9: An executed MFMSR drives the whole register onto `mf_data`. In all other cycles `mf_data` is 0.
- R10: `ls_go` is 1 for a valid LDST operation only when no interrupt is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An instruction is presented this cycle |
| op_code | input | 3 | Operation code (see R4) |
| op_l | input | 1 | Partial-update flag for MTMSR |
| operand | input | 64 | Source value for MTMSR |
| saved_val | input | 64 | Saved register image for RFI |
| insn_word | input | 32 | Raw instruction word; bit 20 marks a privileged special register |
| irq_pending | input | 1 | Asynchronous interrupt pending |
| msr_out | output | 64 | Current register value |
| mf_data | output | 64 | Move-from result |
| take_irq | output | 1 | Asynchronous interrupt taken this cycle |
| priv_fault | output | 1 | Privileged-instruction program interrupt this cycle |
| ls_go | output | 1 | Load/store may be issued this cycle |

## Verification
The hardest state to reach is problem state with a fault pending. PR can only be set through an RFI or a full MTMSR, and the forcing rule then changes three other bits at the same time. The stimulus walks a chained sequence: a full move-to first enables interrupts, then an RFI from an all-ones image enters problem state. From there a move-from with the privilege bit set, a privileged operation racing a pending interrupt, and a later RFI back into problem state each exercise fault priority and interrupt entry. Separate steps hold the interrupt line high with no valid instruction for several cycles, to show that it is deferred.

// File: rtl/msr_pkg.sv
package msr_pkg;
   typedef enum logic [2:0] {
      OP_NOP   = 3'd0,
      OP_MTMSR = 3'd1,
      OP_MFMSR = 3'd2,
      OP_RFI   = 3'd3,
      OP_MTSPR = 3'd4,
      OP_MFSPR = 3'd5,
      OP_PRIV  = 3'd6,
      OP_LDST  = 3'd7
   } msr_op_e;

   localparam int B_SF = 63;
   localparam int B_HV = 60;
   localparam int B_EE = 15;
   localparam int B_PR = 14;
   localparam int B_ME = 12;
   localparam int B_IR = 5;
   localparam int B_DR = 4;
   localparam int B_RI = 1;
   localparam int B_LE = 0;
endpackage

// File: rtl/msr_irq_gate.sv
module msr_irq_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic op_valid,
   input  logic irq_pending,
   input  logic ee,
   output logic take
);
   // Delivery waits for a presented instruction so a stalled op is never split.
   assign take = op_valid & irq_pending & ee;

   a_r3_take_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |-> !take);
endmodule

// File: rtl/msr_priv_check.sv
module msr_priv_check #(
   parameter int INSN_W      = 32,
   parameter int SPR_PRIV_BIT = 20,
   parameter bit MFMSR_PRIV  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  msr_pkg::msr_op_e  op,
   input  logic [INSN_W-1:0] insn_word,
   input  logic              pr,
   input  logic              blocked,
   output logic              fault
);
   import msr_pkg::*;

   logic mf_priv;
   logic is_priv;
   logic unused_insn_bits;

   assign unused_insn_bits = ^insn_word;

   generate
      if (MFMSR_PRIV) begin : g_mf_priv
         assign mf_priv = 1'b1;
      end else begin : g_mf_open
         assign mf_priv = 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (op)
         OP_MTMSR, OP_RFI, OP_PRIV: is_priv = 1'b1;
         OP_MFMSR:                  is_priv = mf_priv;
         OP_MTSPR, OP_MFSPR:        is_priv = insn_word[SPR_PRIV_BIT];
         default:                   is_priv = 1'b0;
      endcase
   end

   assign fault = op_valid & ~blocked & pr & is_priv;

   a_r4_fault_only_in_problem_state: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (pr && op_valid && !blocked));
endmodule

// File: rtl/msr_next_calc.sv
module msr_next_calc #(
   parameter int              XLEN     = 64,
   parameter logic [XLEN-1:0] RFI_KEEP = 64'h1000_FC1E_0000_0000
) (
   input  logic [XLEN-1:0]  msr_q,
   input  msr_pkg::msr_op_e op,
   input  logic             part_l,
   input  logic [XLEN-1:0]  operand,
   input  logic [XLEN-1:0]  saved,
   input  logic             exec,
   input  logic             enter,
   output logic [XLEN-1:0]  msr_d
);
   import msr_pkg::*;

   localparam logic [XLEN-1:0] MT_KEEP =
      (XLEN'(1) << B_HV) | (XLEN'(1) << B_ME) | (XLEN'(1) << B_LE);

   logic [XLEN-1:0] v;
   logic            fix_pr;

   always_comb begin
      v      = msr_q;
      fix_pr = 1'b0;
      if (enter) begin
         v[B_SF] = 1'b1;
         v[B_LE] = 1'b1;
         v[B_PR] = 1'b0;
         v[B_IR] = 1'b0;
         v[B_DR] = 1'b0;
         v[B_RI] = 1'b0;
      end else if (exec) begin
         case (op)
            OP_MTMSR: begin
               if (part_l) begin
                  v[B_EE] = operand[B_EE];
                  v[B_RI] = operand[B_RI];
               end else begin
                  v = (operand & ~MT_KEEP) | (msr_q & MT_KEEP);
               end
               fix_pr = 1'b1;
            end
            OP_RFI: begin
               v      = (saved & ~RFI_KEEP) | (msr_q & RFI_KEEP);
               fix_pr = 1'b1;
            end
            default: ;
         endcase
      end
      if (fix_pr && v[B_PR]) begin
         v[B_EE] = 1'b1;
         v[B_IR] = 1'b1;
         v[B_DR] = 1'b1;
      end
      msr_d = v;
   end
endmodule

// File: rtl/msr_ctrl_unit.sv
module msr_ctrl_unit #(
   parameter int              XLEN         = 64,
   parameter int              INSN_W       = 32,
   parameter int              SPR_PRIV_BIT = 20,
   parameter bit              MFMSR_PRIV   = 1'b1,
   parameter logic [XLEN-1:0] RFI_KEEP     = 64'h1000_FC1E_0000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_code,
   input  logic              op_l,
   input  logic [XLEN-1:0]   operand,
   input  logic [XLEN-1:0]   saved_val,
   input  logic [INSN_W-1:0] insn_word,
   input  logic              irq_pending,
   output logic [XLEN-1:0]   msr_out,
   output logic [XLEN-1:0]   mf_data,
   output logic              take_irq,
   output logic              priv_fault,
   output logic              ls_go
);
   import msr_pkg::*;

   localparam logic [XLEN-1:0] RESET_VAL = (XLEN'(1) << B_SF) | (XLEN'(1) << B_LE);

   generate
      if (XLEN != 64) begin : g_bad_xlen
         $error("msr_ctrl_unit: XLEN must be 64");
      end
      if (SPR_PRIV_BIT >= INSN_W) begin : g_bad_spr_bit
         $error("msr_ctrl_unit: SPR_PRIV_BIT outside instruction word");
      end
   endgenerate

   msr_op_e         op;
   logic [XLEN-1:0] msr_q;
   logic [XLEN-1:0] msr_d;
   logic            exec;
   logic            enter;

   assign op = msr_op_e'(op_code);

   msr_irq_gate u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .op_valid    (op_valid),
      .irq_pending (irq_pending),
      .ee          (msr_q[B_EE]),
      .take        (take_irq)
   );

   msr_priv_check #(
      .INSN_W       (INSN_W),
      .SPR_PRIV_BIT (SPR_PRIV_BIT),
      .MFMSR_PRIV   (MFMSR_PRIV)
   ) u_priv (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_valid  (op_valid),
      .op        (op),
      .insn_word (insn_word),
      .pr        (msr_q[B_PR]),
      .blocked   (take_irq),
      .fault     (priv_fault)
   );

   assign enter = take_irq | priv_fault;
   assign exec  = op_valid & ~enter;

   msr_next_calc #(
      .XLEN     (XLEN),
      .RFI_KEEP (RFI_KEEP)
   ) u_next (
      .msr_q   (msr_q),
      .op      (op),
      .part_l  (op_l),
      .operand (operand),
      .saved   (saved_val),
      .exec    (exec),
      .enter   (enter),
      .msr_d   (msr_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) msr_q <= RESET_VAL;
      else        msr_q <= msr_d;
   end

   assign msr_out = msr_q;
   assign mf_data = (exec && op == OP_MFMSR) ? msr_q : '0;
   assign ls_go   = exec && op == OP_LDST;

   a_r2_entry_fields: assert property (@(posedge clk) disable iff (!rst_n)
      (take_irq || priv_fault) |=> (msr_q[B_SF] && msr_q[B_LE] && !msr_q[B_PR]
                                    && !msr_q[B_IR] && !msr_q[B_DR] && !msr_q[B_RI]));

   a_r5_partial_move_keeps_rest: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && op == OP_MTMSR && op_l) |=>
         (msr_q[XLEN-1:16] == $past(msr_q[XLEN-1:16]) && msr_q[14:2] == $past(msr_q[14:2])
          && msr_q[0] == $past(msr_q[0])));

   a_r6_full_move_keeps_hv_me_le: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && op == OP_MTMSR && !op_l) |=>
         (msr_q[B_HV] == $past(msr_q[B_HV]) && msr_q[B_ME] == $past(msr_q[B_ME])
          && msr_q[B_LE] == $past(msr_q[B_LE])));

   a_r7_problem_state_forces: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && (op == OP_MTMSR || op == OP_RFI)) |=>
         (!msr_q[B_PR] || (msr_q[B_EE] && msr_q[B_IR] && msr_q[B_DR])));

   a_r10_no_ldst_on_take: assert property (@(posedge clk) disable iff (!rst_n)
      ls_go |-> !take_irq);
endmodule

// File: tb/tb_msr_ctrl_unit.sv
module tb_msr_ctrl_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  op_code = 3'd0;
   logic        op_l = 1'b0;
   logic [63:0] operand = '0;
   logic [63:0] saved_val = '0;
   logic [31:0] insn_word = '0;
   logic        irq_pending = 1'b0;
   logic [63:0] msr_out;
   logic [63:0] mf_data;
   logic        take_irq;
   logic        priv_fault;
   logic        ls_go;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   msr_ctrl_unit dut (
      .clk (clk), .rst_n (rst_n), .op_valid (op_valid), .op_code (op_code),
      .op_l (op_l), .operand (operand), .saved_val (saved_val),
      .insn_word (insn_word), .irq_pending (irq_pending), .msr_out (msr_out),
      .mf_data (mf_data), .take_irq (take_irq), .priv_fault (priv_fault),
      .ls_go (ls_go)
   );

   typedef struct packed {
      logic        v;
      logic [2:0]  op;
      logic        l;
      logic [63:0] opnd;
      logic [63:0] sav;
      logic [31:0] insn;
      logic        irq;
      logic        e_take;
      logic        e_fault;
      logic        e_ls;
      logic [63:0] e_mf;
      logic [63:0] e_msr;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      // R9 move-from in supervisor state
      '{1'b1, 3'd2, 1'b0, 64'h0, 64'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001, 4'd9},
      // R3 EE=0 blocks the interrupt, R10 load/store goes
      '{1'b1, 3'd7, 1'b0, 64'h0, 64'h0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1, 64'h0, 64'h8000_0000_0000_0001, 4'd3},
      // R6 full move-to; LE kept, SF taken from operand
      '{1'b1, 3'd1, 1'b0, 64'h0000_0000_0000_8032, 64'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0, 64'h0000_0000_0000_8033, 4'd6},
      // R3 no valid instruction: pending interrupt waits
      '{1'b0, 3'd7, 1'b0, 64'h0, 64'h0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 64'h0, 64'h0000_0000_0000_8033, 4'd3},
      // R2 R10 interrupt taken on a load/store, no issue
      '{1'b1, 3'd7, 1'b0, 64'h0, 64'h0, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, 64'h0, 64'h8000_0000_0000_8001, 4'd2},
      // R5 partial move-to clears EE and RI
      '{1'b1, 3'd1, 1'b1, 64'h0, 64'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0, 64'h8000_0000_0000_0001, 4'd5},
      // R5 partial move-to of all ones sets only EE and RI
      '{1'b1, 3'd1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0, 64'h8000_0000_0000_8003, 4'd5},
      // R8 return from all-ones image keeps HV and partial fields
      '{1'b1, 3'd3, 1'b0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0, 64'hEFFF_03E1_FFFF_FFFF, 4'd8},
      // R4 unprivileged special register in problem state
      '{1'b1, 3'd4, 1'b0, 64'h0, 64'h0, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0, 64'hEFFF_03E1_FFFF_FFFF, 4'd4},
      // R4 privileged special register faults, R2 entry
      '{1'b1, 3'd5, 1'b0, 64'h0, 64'h0, 32'h0010_0000, 1'b0, 1'b0, 1'b1, 1'b0, 64'h0, 64'hEFFF_03E1_FFFF_BFCD, 4'd4},
      // R7 full move-to sets PR, forces EE IR DR
      '{1'b1, 3'd1, 1'b0, 64'h0000_0000_0000_4000, 64'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0, 64'h0000_0000_0000_D031, 4'd7},
      // R3 interrupt outranks a privileged op
      '{1'b1, 3'd6, 1'b0, 64'h0, 64'h0, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, 64'h0, 64'h8000_0000_0000_9001, 4'd3},
      // R6 full move-to of zero keeps ME and LE
      '{1'b1, 3'd1, 1'b0, 64'h0, 64'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0, 64'h0000_0000_0000_1001, 4'd6},
      // R7 return into problem state forces EE IR DR
      '{1'b1, 3'd3, 1'b0, 64'h0, 64'h0000_0000_0000_4000, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0, 64'h0000_0000_0000_C030, 4'd7},
      // R4 move-from in problem state faults, no data
      '{1'b1, 3'd2, 1'b0, 64'h0, 64'h0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 64'h0, 64'h8000_0000_0000_8001, 4'd4},
      // R9 NOP leaves move-from output at zero
      '{1'b1, 3'd0, 1'b0, 64'h0, 64'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0, 64'h8000_0000_0000_8001, 4'd9}
   };

   task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic drive(input logic v, input logic [2:0] op, input logic l,
                        input logic [63:0] opnd, input logic [63:0] sav,
                        input logic [31:0] insn, input logic irq);
      @(negedge clk);
      op_valid = v; op_code = op; op_l = l; operand = opnd;
      saved_val = sav; insn_word = insn; irq_pending = irq;
      #2;
   endtask

   task automatic after_edge();
      @(posedge clk);
      #2;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #4_000_000;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      #2;
      chk("R1 reset msr", msr_out, 64'h8000_0000_0000_0001);
      chk("R1 reset take", {63'd0, take_irq}, 64'd0);
      chk("R1 reset fault", {63'd0, priv_fault}, 64'd0);
      chk("R1 reset ls", {63'd0, ls_go}, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         vec_t t;
         string tag;
         t = VECS[i];
         tag = $sformatf("R%0d step %0d", t.rq, i);
         drive(t.v, t.op, t.l, t.opnd, t.sav, t.insn, t.irq);
         chk({tag, " R3 take"}, {63'd0, take_irq}, {63'd0, t.e_take});
         chk({tag, " R4 fault"}, {63'd0, priv_fault}, {63'd0, t.e_fault});
         chk({tag, " R10 ls"}, {63'd0, ls_go}, {63'd0, t.e_ls});
         chk({tag, " R9 mf"}, mf_data, t.e_mf);
         after_edge();
         chk({tag, " msr"}, msr_out, t.e_msr);
      end

      // R3: interrupt held pending across a stall, EE=1
      for (int k = 0; k < 3; k++) begin
         drive(1'b0, 3'd0, 1'b0, 64'h0, 64'h0, 32'h0, 1'b1);
         chk("R3 stall no take", {63'd0, take_irq}, 64'd0);
         after_edge();
         chk("R3 stall msr held", msr_out, 64'h8000_0000_0000_8001);
      end
      drive(1'b1, 3'd1, 1'b0, 64'h0, 64'h0, 32'h0, 1'b1);
      chk("R3 taken once valid", {63'd0, take_irq}, 64'd1);
      after_edge();
      chk("R2 move-to dropped on take", msr_out, 64'h8000_0000_0000_8001);

      // R6 then R1 again on a mid-run reset
      drive(1'b1, 3'd1, 1'b0, 64'h0, 64'h0, 32'h0, 1'b0);
      after_edge();
      chk("R6 zero move-to", msr_out, 64'h0000_0000_0000_0001);
      @(negedge clk);
      rst_n = 1'b0;
      op_valid = 1'b0;
      #2;
      chk("R1 reset again", msr_out, 64'h8000_0000_0000_0001);
      @(negedge clk);
      rst_n = 1'b1;
      after_edge();
      chk("R1 held after release", msr_out, 64'h8000_0000_0000_0001);

      finish_run();
   end
endmodule